// File: doc/BRIEF.md
# Per-Device Configuration Register Bank

This block holds the configuration registers of every logical device inside a multi-function peripheral controller. Software picks a logical device through a device-number input and then reads or writes one of that device's registers through an 8-bit register index, a write strobe and write data. Read data is a combinational function of the stored state, the index and the device number.

For each device the bank keeps four kinds of state:

- an enable bit;
- a primary 16-bit I/O base address, plus a second one for devices that need it;
- one or two interrupt select bytes;
- a DMA channel byte, for the devices that use DMA.

Which of these registers exist is fixed per device by elaboration parameters. A register that does not exist takes no writes and reads as zero.

A separate power-management path can also write the enable bit, because the enable and power-control bits are one linked bit. Each device has two outputs: an active flag, and a decode-valid flag. Decode-valid is set only while the device is active and its primary base address lies inside that device's permitted, aligned window. Devices use it to gate their own host decoding.

Top module: `ldc_cfg_bank`

## Requirements
- R1: Either reset clears all stored state. `rst_n` low is asynchronous; `bus_rst` high is synchronous and takes priority over any write in the same cycle. After reset every enable bit, base address and interrupt select reads 0x00, and the DMA register reads 0x04 on the devices that implement it.
- R2: Index 0x60 holds bits [15:8] and index 0x61 holds bits [7:0] of the selected device's primary base address. Both exist on every device and read back what was written.
- R3: Indices 0x62 (bits [15:8]) and 0x63 (bits [7:0]) hold a second base address only on devices 1 and 3. On devices 0 and 2 they ignore writes and read 0x00.
- R4: Index 0x70 is an 8-bit interrupt select on every device. Index 0x72 is a second interrupt select that exists only on device 3 and reads 0x00 elsewhere.
- R5: Index 0x74 is an 8-bit DMA channel select on devices 0, 1 and 2 only. Index 0x75 exists on no device.
- R6: Index 0x30 bit 0 is the enable bit. A write stores only wr_data[0], and a read returns {7'b0, enable}.
- R7: A power-control write (`pwr_wr`, `pwr_dev`, `pwr_val`) sets or clears the same enable bit. The new value is visible on the next cycle at index 0x30. If a host write to index 0x30 of the same device happens in the same cycle, the host value wins.
- R8: `dev_active[i]` equals the enable bit of device i.
- R9: `dev_decode_ok[i]` is 1 exactly when device i is active and its primary base lies within [min, max] with its low alignment bits zero. The default windows are:
  - device 0: 0x0100..0x0FF8, 8-aligned;
  - device 1: 0x0100..0x0FFC, 4-aligned;
  - device 2: 0x0100..0x0FF8, 8-aligned;
  - device 3: 0x0060..0x00FF, any alignment.
- R10: Every index not listed in R2 to R6 ignores writes and reads 0x00. This includes 0x31, 0x40-0x5F, 0x71, 0x73 and 0x75-0xFF.
- R11: A device number of 4 or more reads 0x00, and a write to it changes no device's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_rst | input | 1 | Synchronous bus reset, active high |
| dev_sel | input | 8 | Selected logical device number |
| reg_idx | input | 8 | Register index |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Read data for dev_sel / reg_idx |
| pwr_wr | input | 1 | Power-control write strobe |
| pwr_dev | input | 8 | Device targeted by power-control write |
| pwr_val | input | 1 | Power-control value |
| dev_active | output | 4 | Per-device active flag |
| dev_decode_ok | output | 4 | Per-device decode-valid flag |

## Verification
All state is held in flops that feed `rd_data` combinationally. A corrupted field therefore shows up on the very next read of its index, one cycle after the write that should have set it. A wrong enable bit shows on `dev_active` and `dev_decode_ok` in that same cycle, without any read. A device-number decode that aliases out-of-range numbers onto real devices only becomes visible by reading back a device that was never written. The bench therefore reads device 1 after writing device 5.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
    localparam logic [7:0] IDX_ENA  = 8'h30;
    localparam logic [7:0] IDX_B0HI = 8'h60;
    localparam logic [7:0] IDX_B0LO = 8'h61;
    localparam logic [7:0] IDX_B1HI = 8'h62;
    localparam logic [7:0] IDX_B1LO = 8'h63;
    localparam logic [7:0] IDX_IRQA = 8'h70;
    localparam logic [7:0] IDX_IRQB = 8'h72;
    localparam logic [7:0] IDX_DMA  = 8'h74;

    typedef struct packed {
        logic        ena;
        logic [15:0] base0;
        logic [15:0] base1;
        logic [7:0]  irqa;
        logic [7:0]  irqb;
        logic [7:0]  dma;
    } ldc_regs_t;
endpackage

// File: rtl/ldc_dev_regs.sv
module ldc_dev_regs
    import ldc_pkg::*;
#(
    parameter bit         HAS_BASE1 = 1'b0,
    parameter bit         HAS_IRQB  = 1'b0,
    parameter bit         HAS_DMA   = 1'b0,
    parameter logic [7:0] DMA_RST   = 8'h04
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst,
    input  logic       host_wr,
    input  logic [7:0] idx,
    input  logic [7:0] wr_data,
    input  logic       pwr_wr,
    input  logic       pwr_val,
    output ldc_regs_t  regs,
    output logic [7:0] rd_data
);
    localparam logic [7:0] DMA_INIT = HAS_DMA ? DMA_RST : 8'h00;
    localparam ldc_regs_t RST_VAL = '{ena: 1'b0, base0: 16'h0, base1: 16'h0,
                                      irqa: 8'h0, irqb: 8'h0, dma: DMA_INIT};

    ldc_regs_t regs_d, regs_q;
    logic      idx_impl;

    always_comb begin
        regs_d = regs_q;
        if (pwr_wr) regs_d.ena = pwr_val;
        if (host_wr) begin
            case (idx)
                IDX_ENA:  regs_d.ena         = wr_data[0];
                IDX_B0HI: regs_d.base0[15:8] = wr_data;
                IDX_B0LO: regs_d.base0[7:0]  = wr_data;
                IDX_B1HI: if (HAS_BASE1) regs_d.base1[15:8] = wr_data;
                IDX_B1LO: if (HAS_BASE1) regs_d.base1[7:0]  = wr_data;
                IDX_IRQA: regs_d.irqa = wr_data;
                IDX_IRQB: if (HAS_IRQB) regs_d.irqb = wr_data;
                IDX_DMA:  if (HAS_DMA)  regs_d.dma  = wr_data;
                default:  ;
            endcase
        end
        if (bus_rst) regs_d = RST_VAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RST_VAL;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data  = 8'h00;
        idx_impl = 1'b1;
        case (idx)
            IDX_ENA:  rd_data = {7'b0, regs_q.ena};
            IDX_B0HI: rd_data = regs_q.base0[15:8];
            IDX_B0LO: rd_data = regs_q.base0[7:0];
            IDX_B1HI: begin rd_data = HAS_BASE1 ? regs_q.base1[15:8] : 8'h00; idx_impl = HAS_BASE1; end
            IDX_B1LO: begin rd_data = HAS_BASE1 ? regs_q.base1[7:0]  : 8'h00; idx_impl = HAS_BASE1; end
            IDX_IRQA: rd_data = regs_q.irqa;
            IDX_IRQB: begin rd_data = HAS_IRQB ? regs_q.irqb : 8'h00; idx_impl = HAS_IRQB; end
            IDX_DMA:  begin rd_data = HAS_DMA  ? regs_q.dma  : 8'h00; idx_impl = HAS_DMA;  end
            default:  idx_impl = 1'b0;
        endcase
    end

    assign regs = regs_q;

    // R7
    pwr_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_wr && !bus_rst && !(host_wr && idx == IDX_ENA)) |=> (regs_q.ena == $past(pwr_val)));

    // R10
    rsv_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !idx_impl && !pwr_wr && !bus_rst) |=> $stable(regs_q));

    // R1
    dma_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (regs_q.dma == DMA_INIT && regs_q.base0 == 16'h0));
endmodule

// File: rtl/ldc_range_chk.sv
module ldc_range_chk #(
    parameter logic [15:0] MIN_BASE   = 16'h0100,
    parameter logic [15:0] MAX_BASE   = 16'h0FF8,
    parameter logic [15:0] ALIGN_MASK = 16'h0007
) (
    input  logic        active,
    input  logic [15:0] base,
    output logic        ok
);
    logic in_window;
    logic aligned;

    always_comb begin
        in_window = (base >= MIN_BASE) && (base <= MAX_BASE);
        aligned   = (base & ALIGN_MASK) == 16'h0;
        ok        = active && in_window && aligned;
    end
endmodule

// File: rtl/ldc_cfg_bank.sv
module ldc_cfg_bank
    import ldc_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int SEL_W   = 8,
    parameter logic [NUM_DEV-1:0] HAS_BASE1 = 4'b1010,
    parameter logic [NUM_DEV-1:0] HAS_IRQB  = 4'b1000,
    parameter logic [NUM_DEV-1:0] HAS_DMA   = 4'b0111,
    parameter logic [7:0]         DMA_RST   = 8'h04,
    parameter logic [NUM_DEV-1:0][15:0] MIN_BASE   = {16'h0060, 16'h0100, 16'h0100, 16'h0100},
    parameter logic [NUM_DEV-1:0][15:0] MAX_BASE   = {16'h00FF, 16'h0FF8, 16'h0FFC, 16'h0FF8},
    parameter logic [NUM_DEV-1:0][15:0] ALIGN_MASK = {16'h0000, 16'h0007, 16'h0003, 16'h0007}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rst,
    input  logic [SEL_W-1:0]   dev_sel,
    input  logic [7:0]         reg_idx,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    input  logic               pwr_wr,
    input  logic [SEL_W-1:0]   pwr_dev,
    input  logic               pwr_val,
    output logic [NUM_DEV-1:0] dev_active,
    output logic [NUM_DEV-1:0] dev_decode_ok
);
    logic [NUM_DEV-1:0]      host_wr_v;
    logic [NUM_DEV-1:0]      pwr_wr_v;
    logic [NUM_DEV-1:0][7:0] rd_v;
    ldc_regs_t               regs_v [NUM_DEV];

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        assign host_wr_v[i] = wr_en  && (dev_sel == SEL_W'(i));
        assign pwr_wr_v[i]  = pwr_wr && (pwr_dev == SEL_W'(i));

        ldc_dev_regs #(
            .HAS_BASE1 (HAS_BASE1[i]),
            .HAS_IRQB  (HAS_IRQB[i]),
            .HAS_DMA   (HAS_DMA[i]),
            .DMA_RST   (DMA_RST)
        ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .bus_rst (bus_rst),
            .host_wr (host_wr_v[i]),
            .idx     (reg_idx),
            .wr_data (wr_data),
            .pwr_wr  (pwr_wr_v[i]),
            .pwr_val (pwr_val),
            .regs    (regs_v[i]),
            .rd_data (rd_v[i])
        );

        assign dev_active[i] = regs_v[i].ena;

        ldc_range_chk #(
            .MIN_BASE   (MIN_BASE[i]),
            .MAX_BASE   (MAX_BASE[i]),
            .ALIGN_MASK (ALIGN_MASK[i])
        ) u_range (
            .active (regs_v[i].ena),
            .base   (regs_v[i].base0),
            .ok     (dev_decode_ok[i])
        );
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (dev_sel == SEL_W'(i)) rd_data = rd_v[i];
        end
    end

    // R9
    decode_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_decode_ok & ~dev_active) == '0));

    // R11
    oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel >= SEL_W'(NUM_DEV)) |-> (rd_data == 8'h00));

    // R1
    bus_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (dev_active == '0 && dev_decode_ok == '0));
endmodule

// File: tb/tb_ldc_cfg_bank.sv
module tb_ldc_cfg_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic [7:0] dev_sel = 8'h0;
    logic [7:0] reg_idx = 8'h0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h0;
    logic [7:0] rd_data;
    logic       pwr_wr = 1'b0;
    logic [7:0] pwr_dev = 8'h0;
    logic       pwr_val = 1'b0;
    logic [3:0] dev_active;
    logic [3:0] dev_decode_ok;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ldc_cfg_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .dev_sel(dev_sel),
        .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pwr_wr(pwr_wr), .pwr_dev(pwr_dev), .pwr_val(pwr_val),
        .dev_active(dev_active), .dev_decode_ok(dev_decode_ok)
    );

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] dev;
        logic [7:0] idx;
        logic [7:0] wd;
        logic [7:0] ex;
    } vec_t;

    localparam vec_t VECS [0:14] = '{
        '{8'd2,  8'd0, 8'h60, 8'h03, 8'h03},  // R2
        '{8'd2,  8'd0, 8'h61, 8'hF0, 8'hF0},  // R2
        '{8'd3,  8'd0, 8'h62, 8'h12, 8'h00},  // R3
        '{8'd3,  8'd1, 8'h62, 8'h12, 8'h12},  // R3
        '{8'd3,  8'd1, 8'h63, 8'h34, 8'h34},  // R3
        '{8'd4,  8'd2, 8'h72, 8'h05, 8'h00},  // R4
        '{8'd4,  8'd3, 8'h72, 8'h05, 8'h05},  // R4
        '{8'd4,  8'd2, 8'h70, 8'h44, 8'h44},  // R4
        '{8'd5,  8'd3, 8'h74, 8'h02, 8'h00},  // R5
        '{8'd5,  8'd2, 8'h74, 8'h02, 8'h02},  // R5
        '{8'd5,  8'd1, 8'h75, 8'h02, 8'h00},  // R5
        '{8'd6,  8'd0, 8'h30, 8'hFF, 8'h01},  // R6
        '{8'd10, 8'd0, 8'h50, 8'hAA, 8'h00},  // R10
        '{8'd10, 8'd1, 8'h71, 8'h11, 8'h00},  // R10
        '{8'd11, 8'd5, 8'h60, 8'h11, 8'h00}   // R11
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic [7:0] i, input logic [7:0] v);
        @(negedge clk);
        dev_sel = d; reg_idx = i; wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] d, input logic [7:0] i, output logic [7:0] v);
        dev_sel = d; reg_idx = i;
        #1;
        v = rd_data;
    endtask

    task automatic pwr(input logic [7:0] d, input logic v);
        @(negedge clk);
        pwr_dev = d; pwr_val = v; pwr_wr = 1'b1;
        @(negedge clk);
        pwr_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'd0, 8'h74, v); chk("R1 dma dev0", v, 8'h04);
        rd(8'd3, 8'h74, v); chk("R1 dma dev3", v, 8'h00);
        rd(8'd0, 8'h60, v); chk("R1 base dev0", v, 8'h00);
        rd(8'd1, 8'h70, v); chk("R1 irq dev1", v, 8'h00);
        chk("R1 active", {4'b0, dev_active}, 8'h00);

        for (int k = 0; k < 15; k++) begin
            wr(VECS[k].dev, VECS[k].idx, VECS[k].wd);
            rd(VECS[k].dev, VECS[k].idx, v);
            chk($sformatf("R%0d vec %0d", VECS[k].req, k), v, VECS[k].ex);
        end

        // R11 device 5 must not alias onto device 1
        rd(8'd1, 8'h60, v); chk("R11 no alias", v, 8'h00);
        // R10 reserved write left base intact
        rd(8'd0, 8'h60, v); chk("R10 base kept", v, 8'h03);
        wr(8'd0, 8'h31, 8'hFF);
        rd(8'd0, 8'h31, v); chk("R10 idx31", v, 8'h00);

        // R8 / R9 base 0x03F0, active
        chk("R8 active dev0", {7'b0, dev_active[0]}, 8'h01);
        chk("R9 decode ok", {7'b0, dev_decode_ok[0]}, 8'h01);
        wr(8'd0, 8'h61, 8'hF4);
        #1 chk("R9 misaligned", {7'b0, dev_decode_ok[0]}, 8'h00);
        chk("R8 still active", {7'b0, dev_active[0]}, 8'h01);
        wr(8'd0, 8'h60, 8'h00); wr(8'd0, 8'h61, 8'h80);
        #1 chk("R9 below min", {7'b0, dev_decode_ok[0]}, 8'h00);
        wr(8'd0, 8'h60, 8'h10); wr(8'd0, 8'h61, 8'h00);
        #1 chk("R9 above max", {7'b0, dev_decode_ok[0]}, 8'h00);
        wr(8'd0, 8'h60, 8'h03); wr(8'd0, 8'h61, 8'hF0);
        #1 chk("R9 restored", {7'b0, dev_decode_ok[0]}, 8'h01);

        // R7 power-control path
        pwr(8'd0, 1'b0);
        rd(8'd0, 8'h30, v); chk("R7 pwr clear", v, 8'h00);
        chk("R8 inactive", {7'b0, dev_active[0]}, 8'h00);
        chk("R9 inactive no decode", {7'b0, dev_decode_ok[0]}, 8'h00);
        pwr(8'd2, 1'b1);
        chk("R7 pwr set dev2", {4'b0, dev_active}, 8'h04);
        @(negedge clk);
        dev_sel = 8'd2; reg_idx = 8'h30; wr_data = 8'h00; wr_en = 1'b1;
        pwr_dev = 8'd2; pwr_val = 1'b1; pwr_wr = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; pwr_wr = 1'b0;
        chk("R7 host wins", {7'b0, dev_active[2]}, 8'h00);

        // R1 bus reset
        wr(8'd3, 8'h30, 8'h01);
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        rd(8'd2, 8'h74, v); chk("R1 bus rst dma", v, 8'h04);
        rd(8'd1, 8'h62, v); chk("R1 bus rst base1", v, 8'h00);
        chk("R1 bus rst active", {4'b0, dev_active}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule